// File: doc/BRIEF.md
# Page Write Collector with In-Page Address Wrap

This block gathers the data bytes of one page-write burst for a serial memory device. A burst opens when a starting word address is loaded. That address holds a page row in its upper bits and a byte offset in its low bits. Each data strobe places one byte at the current offset and then advances only the offset bits, so the address wraps inside the page and never reaches the next row. When the burst is longer than the page, the extra bytes overwrite earlier bytes of the same burst.

A stop strobe closes the burst. The block then walks every page location in ascending order, one location per cycle, and drives a write toward the array for each location that received a byte during the burst. The page size is set by `PAGE_BYTES`: 8 for the small densities and 16 for the larger ones. The protocol of the serial bus and the timing of the nonvolatile write belong to other blocks.

The controller has three states. `ST_IDLE` means no burst is open. `ST_FILL` means a burst is collecting bytes. `ST_FLUSH` means the page is being written to the array. The transitions are:
- IDLE to FILL on a load.
- FILL to FILL on a further load, which restarts the burst.
- FILL to FLUSH on a stop.
- FLUSH to IDLE after the last location has been scanned.

Top module: `page_wr_buf`

## Requirements
- R1: After reset, `cur_addr` is 0, all `buf_vld` bits are 0, and `busy` and `cm_we` are low.
- R2: A load (`ld_en`) while not flushing sets `cur_addr` to `ld_addr` on the next cycle and clears every `buf_vld` bit. A load during FILL restarts the burst.
- R3: A data strobe during FILL with no load in the same cycle does three things: it stores `byte_data` at the location given by the low log2(PAGE_BYTES) bits of `cur_addr`, it sets that location's valid bit, and it adds one to those low bits. The upper bits stay unchanged.
- R4: When the offset is at the last location, the next strobe wraps it to location 0 of the same row. Later bytes overwrite earlier ones, and valid bits never exceed one per location.
- R5: A stop during FILL makes `busy` high for exactly PAGE_BYTES cycles, starting on the next cycle. A data strobe in the same cycle as the stop is still stored.
- R6: During the scan, `cm_we` is high once for each valid location, in ascending offset order. `cm_addr` is the row bits followed by the offset, and `cm_data` is the byte stored at that location.
- R7: While `busy` is high, data strobes and loads are ignored. `cur_addr`, `buf_data` and `buf_vld` stay unchanged.
- R8: In IDLE, data strobes and stops are ignored. No scan starts, and the buffer, valid bits and address stay unchanged.
- R9: A burst of a single byte followed by a stop produces exactly one array write, at the loaded address.
- R10: After the scan, the block returns to IDLE and keeps the address, the buffered bytes and the valid bits until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_en | input | 1 | Load starting address, opens burst |
| ld_addr | input | ADDR_W | Starting word address (row and offset) |
| byte_en | input | 1 | Data byte strobe |
| byte_data | input | DATA_W | Data byte |
| stop_en | input | 1 | Closes burst, starts commit |
| cur_addr | output | ADDR_W | Current internal word address |
| buf_data | output | PAGE_BYTES*DATA_W | Buffered bytes, location 0 in the low bits |
| buf_vld | output | PAGE_BYTES | Per-location written flags |
| busy | output | 1 | Commit scan in progress |
| cm_we | output | 1 | Array write enable |
| cm_addr | output | ADDR_W | Array write address |
| cm_data | output | DATA_W | Array write data |

## Verification
An offset counter that carries into the row bits would show up on `cur_addr` in the cycle after the wrapping strobe. A wrong store location would show up in `buf_data` and `buf_vld` in the cycle after that strobe. A scan that is off by one in index, or in length, would show up over the PAGE_BYTES cycles after a stop, as a write sequence or `busy` window that differs from the expected one. A controller that leaves FLUSH or IDLE on a stray strobe would change the address or buffer on the next cycle, and it would also raise `busy` when no scan was due.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_FLUSH = 2'd2
    } pwb_state_e;
endpackage

// File: rtl/pwb_addr_track.sv
module pwb_addr_track #(
    parameter int ADDR_W = 11,
    parameter int OFS_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);
    localparam int ROW_W = ADDR_W - OFS_W;

    logic [ROW_W-1:0] row_q;
    logic [OFS_W-1:0] ofs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q <= '0;
            ofs_q <= '0;
        end else if (load) begin
            row_q <= load_addr[ADDR_W-1:OFS_W];
            ofs_q <= load_addr[OFS_W-1:0];
        end else if (step) begin
            // offset wraps inside the page; row is never touched
            ofs_q <= ofs_q + 1'b1;
        end
    end

    assign addr = {row_q, ofs_q};
endmodule

// File: rtl/pwb_page_store.sv
module pwb_page_store #(
    parameter int PAGE_BYTES = 16,
    parameter int DATA_W     = 8,
    parameter int OFS_W      = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         wr,
    input  logic [OFS_W-1:0]             wr_ofs,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [OFS_W-1:0]             rd_ofs,
    output logic [PAGE_BYTES*DATA_W-1:0] all_data,
    output logic [PAGE_BYTES-1:0]        all_vld,
    output logic [DATA_W-1:0]            rd_data,
    output logic                         rd_vld
);
    logic [DATA_W-1:0] mem [PAGE_BYTES];

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_loc
        logic hit;
        assign hit = wr && (wr_ofs == OFS_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[g]     <= '0;
                all_vld[g] <= 1'b0;
            end else begin
                if (clr)
                    all_vld[g] <= 1'b0;
                else if (hit)
                    all_vld[g] <= 1'b1;
                if (hit)
                    mem[g] <= wr_data;
            end
        end

        assign all_data[g*DATA_W +: DATA_W] = mem[g];
    end

    assign rd_data = mem[rd_ofs];
    assign rd_vld  = all_vld[rd_ofs];
endmodule

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
    import pwb_pkg::*;
#(
    parameter int PAGE_BYTES = 16,
    parameter int OFS_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic             byte_en,
    input  logic             stop_en,
    output logic             do_load,
    output logic             do_store,
    output logic             flushing,
    output logic [OFS_W-1:0] scan_idx,
    output pwb_state_e       state
);
    localparam logic [OFS_W-1:0] LAST_IDX = OFS_W'(PAGE_BYTES - 1);

    pwb_state_e       st_q, st_d;
    logic [OFS_W-1:0] idx_q, idx_d;

    // next-state logic
    always_comb begin
        st_d  = st_q;
        idx_d = idx_q;
        unique case (st_q)
            ST_IDLE: begin
                if (ld_en) st_d = ST_FILL;
            end
            ST_FILL: begin
                if (ld_en) begin
                    st_d = ST_FILL;
                end else if (stop_en) begin
                    st_d  = ST_FLUSH;
                    idx_d = '0;
                end
            end
            ST_FLUSH: begin
                if (idx_q == LAST_IDX) begin
                    st_d  = ST_IDLE;
                    idx_d = '0;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            default: begin
                st_d  = ST_IDLE;
                idx_d = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            idx_q <= '0;
        end else begin
            st_q  <= st_d;
            idx_q <= idx_d;
        end
    end

    // outputs
    always_comb begin
        do_load  = 1'b0;
        do_store = 1'b0;
        flushing = 1'b0;
        unique case (st_q)
            ST_IDLE:  do_load  = ld_en;
            ST_FILL: begin
                do_load  = ld_en;
                do_store = byte_en && !ld_en;
            end
            ST_FLUSH: flushing = 1'b1;
            default: ;
        endcase
    end

    assign scan_idx = idx_q;
    assign state    = st_q;
endmodule

// File: rtl/page_wr_buf.sv
module page_wr_buf
    import pwb_pkg::*;
#(
    parameter int PAGE_BYTES = 16,
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ld_en,
    input  logic [ADDR_W-1:0]            ld_addr,
    input  logic                         byte_en,
    input  logic [DATA_W-1:0]            byte_data,
    input  logic                         stop_en,
    output logic [ADDR_W-1:0]            cur_addr,
    output logic [PAGE_BYTES*DATA_W-1:0] buf_data,
    output logic [PAGE_BYTES-1:0]        buf_vld,
    output logic                         busy,
    output logic                         cm_we,
    output logic [ADDR_W-1:0]            cm_addr,
    output logic [DATA_W-1:0]            cm_data
);
    localparam int OFS_W = $clog2(PAGE_BYTES);

    logic             do_load, do_store, flushing, rd_vld;
    logic [OFS_W-1:0] scan_idx;
    logic [DATA_W-1:0] rd_data;
    pwb_state_e       st;

    pwb_ctrl #(.PAGE_BYTES(PAGE_BYTES), .OFS_W(OFS_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_en    (ld_en),
        .byte_en  (byte_en),
        .stop_en  (stop_en),
        .do_load  (do_load),
        .do_store (do_store),
        .flushing (flushing),
        .scan_idx (scan_idx),
        .state    (st)
    );

    pwb_addr_track #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (do_load),
        .load_addr (ld_addr),
        .step      (do_store),
        .addr      (cur_addr)
    );

    pwb_page_store #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W), .OFS_W(OFS_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (do_load),
        .wr       (do_store),
        .wr_ofs   (cur_addr[OFS_W-1:0]),
        .wr_data  (byte_data),
        .rd_ofs   (scan_idx),
        .all_data (buf_data),
        .all_vld  (buf_vld),
        .rd_data  (rd_data),
        .rd_vld   (rd_vld)
    );

    assign busy    = flushing;
    assign cm_we   = flushing && rd_vld;
    assign cm_addr = {cur_addr[ADDR_W-1:OFS_W], scan_idx};
    assign cm_data = rd_data;
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker
    import pwb_pkg::*;
#(
    parameter int PAGE_BYTES = 16,
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         ld_en,
    input logic [ADDR_W-1:0]            ld_addr,
    input logic                         byte_en,
    input logic [ADDR_W-1:0]            cur_addr,
    input logic [PAGE_BYTES*DATA_W-1:0] buf_data,
    input logic [PAGE_BYTES-1:0]        buf_vld,
    input logic                         busy,
    input logic                         cm_we,
    input pwb_state_e                   st
);
    localparam int OFS_W = $clog2(PAGE_BYTES);
    localparam int CW    = OFS_W + 2;

    logic [CW-1:0] run_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_cnt <= '0;
        else if (busy) run_cnt <= run_cnt + 1'b1;
        else           run_cnt <= '0;
    end

    AST_RESET_CLEAN: assert property (@(posedge clk) !rst_n |-> (!busy && !cm_we && buf_vld == '0)); // R1
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && !busy) |=> (cur_addr == $past(ld_addr) && buf_vld == '0)); // R2
    AST_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FILL && byte_en && !ld_en) |=>
        (cur_addr[ADDR_W-1:OFS_W] == $past(cur_addr[ADDR_W-1:OFS_W]))); // R3
    AST_OFS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FILL && byte_en && !ld_en) |=>
        (cur_addr[OFS_W-1:0] == OFS_W'($past(cur_addr[OFS_W-1:0]) + 1'b1))); // R4
    AST_SCAN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_cnt == CW'(PAGE_BYTES))); // R5
    AST_WE_IN_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        cm_we |-> busy); // R6
    AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(cur_addr) && $stable(buf_data) && $stable(buf_vld))); // R7
    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !ld_en) |=> ($stable(cur_addr) && $stable(buf_vld) && !busy)); // R8
endmodule

bind page_wr_buf pwb_checker #(
    .PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .byte_en(byte_en),
    .cur_addr(cur_addr), .buf_data(buf_data), .buf_vld(buf_vld), .busy(busy),
    .cm_we(cm_we), .st(st)
);

// File: tb/tb_page_wr_buf.sv
`timescale 1ns/1ps
module tb_page_wr_buf;
    localparam int PB = 16;
    localparam int AW = 11;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ld_en = 1'b0, byte_en = 1'b0, stop_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [DW-1:0] byte_data = '0;
    logic [AW-1:0] cur_addr, cm_addr;
    logic [PB*DW-1:0] buf_data;
    logic [PB-1:0] buf_vld;
    logic busy, cm_we;
    logic [DW-1:0] cm_data;

    always #2.5 clk = ~clk;

    page_wr_buf #(.PAGE_BYTES(PB), .ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr),
        .byte_en(byte_en), .byte_data(byte_data), .stop_en(stop_en),
        .cur_addr(cur_addr), .buf_data(buf_data), .buf_vld(buf_vld),
        .busy(busy), .cm_we(cm_we), .cm_addr(cm_addr), .cm_data(cm_data)
    );

    int total = 0;
    int bad = 0;

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // requirement model of the buffer
    logic [DW-1:0] m_data [PB];
    logic [PB-1:0] m_vld = '0;
    logic [AW-1:0] m_addr = '0;

    task automatic m_load(logic [AW-1:0] a);
        m_addr = a;
        m_vld  = '0;
    endtask

    task automatic m_byte(logic [DW-1:0] d);
        m_data[m_addr[3:0]] = d;
        m_vld[m_addr[3:0]]  = 1'b1;
        m_addr[3:0] = m_addr[3:0] + 4'd1;
    endtask

    // op: 0 load, 1 data byte, 2 nothing
    typedef struct packed {
        logic [1:0]    op;
        logic [AW-1:0] val;
        logic [AW-1:0] exp;
    } vec_t;

    localparam vec_t VT [8] = '{
        '{2'd0, 11'h1FE, 11'h1FE},  // R2 load
        '{2'd1, 11'h011, 11'h1FF},  // R3 step
        '{2'd1, 11'h022, 11'h1F0},  // R4 wrap to location 0
        '{2'd1, 11'h033, 11'h1F1},  // R3
        '{2'd2, 11'h000, 11'h1F1},  // no strobe
        '{2'd1, 11'h044, 11'h1F2},  // R3
        '{2'd0, 11'h2A7, 11'h2A7},  // R2 reload clears flags
        '{2'd1, 11'h055, 11'h2A8}   // R3
    };

    task automatic do_commit(string req);
        int nb = 0;
        int nw = 0;
        logic [AW-1:0] wa [PB];
        logic [DW-1:0] wd [PB];
        int k = 0;
        stop_en = 1'b1;
        @(negedge clk);
        stop_en = 1'b0;
        repeat (PB + 3) begin
            if (busy) nb++;
            if (cm_we && nw < PB) begin
                wa[nw] = cm_addr;
                wd[nw] = cm_data;
                nw++;
            end
            @(negedge clk);
        end
        check({req, " R5 busy length"}, nb, PB);
        check({req, " R6 write count"}, nw, $countones(m_vld));
        for (int i = 0; i < PB; i++) begin
            if (m_vld[i] && k < nw) begin
                check({req, " R6 write addr"}, wa[k], {m_addr[AW-1:4], 4'(i)});
                check({req, " R6 write data"}, wd[k], m_data[i]);
                k++;
            end
        end
        check({req, " R10 back to idle"}, busy, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [AW-1:0] sa;
        logic [PB*DW-1:0] sd;
        logic [PB-1:0] sv;

        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 cur_addr", cur_addr, 0);
        check("R1 buf_vld", buf_vld, 0);
        check("R1 busy", busy, 0);
        check("R1 cm_we", cm_we, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // vector table
        foreach (VT[i]) begin
            ld_en   = (VT[i].op == 2'd0);
            byte_en = (VT[i].op == 2'd1);
            ld_addr = VT[i].val;
            byte_data = VT[i].val[DW-1:0];
            if (VT[i].op == 2'd0) m_load(VT[i].val);
            if (VT[i].op == 2'd1) m_byte(VT[i].val[DW-1:0]);
            @(negedge clk);
            ld_en = 1'b0;
            byte_en = 1'b0;
            check($sformatf("R2/R3/R4 vec %0d addr", i), cur_addr, VT[i].exp);
            check($sformatf("R3 vec %0d vld", i), buf_vld, m_vld);
        end
        check("R3 stored byte", buf_data[7*DW +: DW], 8'h55);

        // R9 single byte burst commits exactly one write at the load address
        do_commit("R9");

        // R10 retained after scan
        check("R10 addr kept", cur_addr, 11'h2A8);
        check("R10 vld kept", buf_vld, m_vld);

        // R8 idle ignores strobes and stop
        sa = cur_addr; sv = buf_vld; sd = buf_data;
        byte_en = 1'b1; byte_data = 8'hEE; stop_en = 1'b1;
        @(negedge clk);
        byte_en = 1'b0; stop_en = 1'b0;
        check("R8 no scan", busy, 0);
        check("R8 addr", cur_addr, sa);
        check("R8 data", buf_data, sd);
        @(negedge clk);
        check("R8 no scan later", busy, 0);
        check("R8 vld", buf_vld, sv);

        // R4 overflow: 17 bytes into one page
        ld_en = 1'b1; ld_addr = 11'h235; m_load(11'h235);
        @(negedge clk);
        ld_en = 1'b0;
        for (int j = 0; j < PB + 1; j++) begin
            byte_en = 1'b1; byte_data = 8'(8'h80 + j); m_byte(8'(8'h80 + j));
            @(negedge clk);
        end
        byte_en = 1'b0;
        check("R4 addr after 17", cur_addr, 11'h236);
        check("R4 all valid", buf_vld, {PB{1'b1}});
        check("R4 overwritten byte", buf_data[5*DW +: DW], 8'h90);
        check("R4 neighbour kept", buf_data[6*DW +: DW], 8'h81);

        // R5 stop with byte in same cycle, then R7 strobes during scan
        byte_en = 1'b1; byte_data = 8'h3C; m_byte(8'h3C); stop_en = 1'b1;
        @(negedge clk);
        byte_en = 1'b0; stop_en = 1'b0;
        check("R5 busy after stop", busy, 1);
        check("R5 same-cycle byte stored", buf_data[6*DW +: DW], 8'h3C);
        sa = cur_addr; sd = buf_data; sv = buf_vld;
        ld_en = 1'b1; ld_addr = 11'h000; byte_en = 1'b1; byte_data = 8'hAA;
        @(negedge clk);
        ld_en = 1'b0; byte_en = 1'b0;
        check("R7 addr frozen", cur_addr, sa);
        check("R7 data frozen", buf_data, sd);
        check("R7 vld frozen", buf_vld, sv);
        repeat (PB) @(negedge clk);
        check("R5 scan ended", busy, 0);
        check("R7 addr still", cur_addr, 11'h237);

        // full-page commit with sparse flags
        ld_en = 1'b1; ld_addr = 11'h14D; m_load(11'h14D);
        @(negedge clk);
        ld_en = 1'b0;
        for (int j = 0; j < 5; j++) begin
            byte_en = 1'b1; byte_data = 8'(8'hC0 + j); m_byte(8'(8'hC0 + j));
            @(negedge clk);
        end
        byte_en = 1'b0;
        check("R4 wrap row kept", cur_addr, 11'h142);
        do_commit("R6 sparse");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule